// File: doc/BRIEF.md
# Disk Sector Write Sequencer

This block drives the serial write stream and the write gate of a disk head for one sector. A sector holds a fixed number of records. Each record is written as a field made of a run of zero bits, a single one bit that marks where the field starts, the record's data words, and a check word. Software or a controller upstream arms the sequencer with a start pulse. The sequencer then waits for the sector mark and sends one bit on every bit-clock tick. It takes the data words from a simple valid/ready source.

Two operations exist. A full write lays down every record of the sector, starting after an optional guard interval that follows the sector mark. An update first reads a number of leading records from the head, locating each one by its start bit and checking its check word, and then turns the write gate on to overwrite the remaining records. The turn-on happens at the bit time right after the last bit read, and the written fields get a longer zero run so that a later read still finds them. After the last check word the gate stays on for a trailing run of zeros. Only then does it fall, with a done pulse. A sector mark that arrives while the sequencer is busy ends the operation at once.

Top module: `sector_write_seq`

## Requirements
- R1: During and right after reset, wr_gate_o, wr_data_o, done_o, word_ready_o and chk_fail_o are all low.
- R2: In a full write, wr_gate_o rises on the (GUARD_TICKS+1)-th bit tick after the sector mark, and never rises without a sector mark having been seen after start_i.
- R3: Each written field is a preamble of zero bits, then exactly one 1 bit as sync, then REC_WORDS words most significant bit first, then the check word. The preamble is PRE_FULL bits in a full write and PRE_UPD bits in an update. wr_data_o changes only on a bit tick and is 0 whenever wr_gate_o is low.
- R4: The check word of a field is 16'h0151 XOR every data word of that field.
- R5: After the last record's check word, wr_gate_o stays high for POST_BITS zero bits and falls on the following bit tick. done_o pulses for one cycle in the cycle in which wr_gate_o falls.
- R6: A sector mark while an operation is under way drives wr_gate_o and wr_data_o low and pulses done_o in the next cycle. The rest of the sector is not written.
- R7: In an update with keep_i = k (1 to N_RECS-1), the block reads k records from rd_bit_i. Each record is located by the first 1 bit after the mark or after the previous record, and is followed by REC_WORDS words and a check word, most significant bit first. wr_gate_o rises on the first bit tick after the last check bit of record k, and records k to N_RECS-1 are then written.
- R8: A read record whose check word differs from 16'h0151 XOR its words gives exactly one chk_fail_o pulse. A matching record gives none. Either way, writing goes ahead.
- R9: word_ready_o is high only in the cycle in which a word is taken: the sync bit tick of a field, and the tick that sends the last bit of each word that is not the last one of its field. If word_valid_i is low at that moment, an all-zero word is written and folded into the check word.
- R10: start_i is ignored while an operation is armed or running, and a sector mark is ignored while the block is idle.
- R11: An update with keep_i = 0 behaves exactly like a full write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arms one operation when idle |
| update_i | input | 1 | Selects update (1) or full write (0), sampled with start_i |
| keep_i | input | $clog2(N_RECS) | Number of leading records to read in an update |
| sector_mark_i | input | 1 | One-cycle pulse at each sector mark |
| bit_tick_i | input | 1 | One-cycle bit-clock enable, at least two cycles apart, never in the same cycle as a mark |
| rd_bit_i | input | 1 | Serial read data, sampled on bit ticks |
| word_i | input | 16 | Data word from the source |
| word_valid_i | input | 1 | Source has a word |
| word_ready_o | output | 1 | Word taken this cycle |
| wr_data_o | output | 1 | Serial write data |
| wr_gate_o | output | 1 | Write gate |
| done_o | output | 1 | One-cycle pulse at the end of an operation |
| chk_fail_o | output | 1 | One-cycle pulse for a read record with a bad check word |

## Verification
The bench builds the block with three records of two words, preambles of 4 and 8 bits, a 5-bit postamble and a 3-tick guard. With these sizes a whole sector fits in a couple of hundred bit times, so every bit of each operation is compared against a stream computed in the bench. The sweep covers full writes with several word patterns, updates keeping zero, one and two records, a corrupted read record, an absent word source, and aborts by an early sector mark. The short fields make it cheap to look at every boundary: preamble-to-sync, word-to-word, check-to-next-field and the drop after the postamble.

// File: rtl/sws_pkg.sv
package sws_pkg;
  localparam int unsigned WORD_W = 16;
  localparam logic [WORD_W-1:0] CHK_SEED = 16'h0151;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_READ, ST_GUARD, ST_PRE, ST_DATA, ST_CHECK, ST_POST
  } sws_state_e;
endpackage

// File: rtl/sws_tx_shift.sv
module sws_tx_shift
  import sws_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              first_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              chk_i,
  input  logic              shift_i,
  output logic              msb_o
);
  logic [WORD_W-1:0] sh_q, acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      acc_q <= CHK_SEED;
    end else if (load_i) begin
      sh_q  <= word_i;
      acc_q <= (first_i ? CHK_SEED : acc_q) ^ word_i;
    end else if (chk_i) begin
      sh_q <= acc_q;
    end else if (shift_i) begin
      sh_q <= {sh_q[WORD_W-2:0], 1'b0};
    end
  end

  assign msb_o = sh_q[WORD_W-1];

  // R4: controls are mutually exclusive, so the check word is never corrupted
  a_r4_one_action: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({load_i, chk_i, shift_i}) <= 1);
endmodule

// File: rtl/sws_rx_record.sv
module sws_rx_record
  import sws_pkg::*;
#(
  parameter int unsigned REC_WORDS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic bit_i,
  output logic done_o,
  output logic bad_o
);
  localparam int unsigned BW    = $clog2(WORD_W);
  localparam int unsigned WIX_W = $clog2(REC_WORDS + 1);
  localparam logic [BW-1:0]    LAST_BIT = BW'(WORD_W - 1);
  localparam logic [WIX_W-1:0] CHK_IDX  = WIX_W'(REC_WORDS);

  logic              hunt_q;
  logic [BW-1:0]     bcnt_q;
  logic [WIX_W-1:0]  wcnt_q;
  logic [WORD_W-1:0] sh_q, acc_q;
  logic [WORD_W-1:0] word_d;

  assign word_d = {sh_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hunt_q <= 1'b1;
      bcnt_q <= '0;
      wcnt_q <= '0;
      sh_q   <= '0;
      acc_q  <= CHK_SEED;
      done_o <= 1'b0;
      bad_o  <= 1'b0;
    end else if (!en_i) begin
      hunt_q <= 1'b1;
      bcnt_q <= '0;
      wcnt_q <= '0;
      acc_q  <= CHK_SEED;
      done_o <= 1'b0;
      bad_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      bad_o  <= 1'b0;
      if (tick_i) begin
        if (hunt_q) begin
          // first 1 after the zero run is the sync bit
          if (bit_i) begin
            hunt_q <= 1'b0;
            bcnt_q <= '0;
            wcnt_q <= '0;
          end
        end else begin
          sh_q <= word_d;
          if (bcnt_q == LAST_BIT) begin
            bcnt_q <= '0;
            if (wcnt_q == CHK_IDX) begin
              done_o <= 1'b1;
              bad_o  <= (word_d != acc_q);
              hunt_q <= 1'b1;
              wcnt_q <= '0;
              acc_q  <= CHK_SEED;
            end else begin
              acc_q  <= acc_q ^ word_d;
              wcnt_q <= wcnt_q + 1'b1;
            end
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
      end
    end
  end

  a_r8_bad_only_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_o |-> done_o);
  a_r7_done_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(tick_i && en_i));
endmodule

// File: rtl/sector_write_seq.sv
module sector_write_seq
  import sws_pkg::*;
#(
  parameter int unsigned N_RECS      = 3,
  parameter int unsigned REC_WORDS   = 2,
  parameter int unsigned PRE_FULL    = 16,
  parameter int unsigned PRE_UPD     = 32,
  parameter int unsigned POST_BITS   = 24,
  parameter int unsigned GUARD_TICKS = 0,
  localparam int unsigned REC_W      = $clog2(N_RECS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              update_i,
  input  logic [REC_W-1:0]  keep_i,
  input  logic              sector_mark_i,
  input  logic              bit_tick_i,
  input  logic              rd_bit_i,
  input  logic [15:0]       word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic              wr_data_o,
  output logic              wr_gate_o,
  output logic              done_o,
  output logic              chk_fail_o
);
  localparam int unsigned MAX_A = (PRE_FULL > PRE_UPD) ? PRE_FULL : PRE_UPD;
  localparam int unsigned MAX_B = (POST_BITS > WORD_W) ? POST_BITS : WORD_W;
  localparam int unsigned MAXL  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W = $clog2(MAXL + 1);
  localparam int unsigned WIX_W = $clog2(REC_WORDS + 1);
  localparam int unsigned GD_W  = $clog2(GUARD_TICKS + 2);

  localparam logic [CNT_W-1:0] PRE_F_C  = CNT_W'(PRE_FULL);
  localparam logic [CNT_W-1:0] PRE_U_C  = CNT_W'(PRE_UPD);
  localparam logic [CNT_W-1:0] POST_C   = CNT_W'(POST_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [WIX_W-1:0] LAST_WD  = WIX_W'(REC_WORDS - 1);
  localparam logic [REC_W-1:0] LAST_REC = REC_W'(N_RECS - 1);
  localparam logic [GD_W-1:0]  GUARD_C  = GD_W'(GUARD_TICKS);

  sws_state_e        st_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [WIX_W-1:0]  word_idx_q;
  logic [REC_W-1:0]  rec_idx_q, keep_q;
  logic [GD_W-1:0]   guard_q;
  logic              upd_q;
  logic              gate_q, data_q, done_q;

  logic [CNT_W-1:0]  pre_len;
  logic              step, pre_end, word_end, last_word, last_rec;
  logic              in_pre, in_data, in_chk;
  logic              tx_load, tx_chk, tx_shift, tx_msb;
  logic              rx_en, rx_done, rx_bad;
  logic [15:0]       word_in;

  assign pre_len   = upd_q ? PRE_U_C : PRE_F_C;
  assign step      = bit_tick_i & ~sector_mark_i;
  assign pre_end   = (bit_cnt_q == pre_len);
  assign word_end  = (bit_cnt_q == LAST_BIT);
  assign last_word = (word_idx_q == LAST_WD);
  assign last_rec  = (rec_idx_q == LAST_REC);
  assign in_pre    = (st_q == ST_PRE);
  assign in_data   = (st_q == ST_DATA);
  assign in_chk    = (st_q == ST_CHECK);
  assign word_in   = word_valid_i ? word_i : '0;

  // words are taken on the sync tick and on the last bit of a non-final word
  assign tx_load  = step & ((in_pre & pre_end) | (in_data & word_end & ~last_word));
  assign tx_chk   = step & in_data & word_end & last_word;
  assign tx_shift = step & (in_data | in_chk) & ~tx_load & ~tx_chk;

  sws_tx_shift u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tx_load),
    .first_i (in_pre),
    .word_i  (word_in),
    .chk_i   (tx_chk),
    .shift_i (tx_shift),
    .msb_o   (tx_msb)
  );

  assign rx_en = (st_q == ST_READ);

  sws_rx_record #(.REC_WORDS(REC_WORDS)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_en),
    .tick_i (bit_tick_i),
    .bit_i  (rd_bit_i),
    .done_o (rx_done),
    .bad_o  (rx_bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      bit_cnt_q  <= '0;
      word_idx_q <= '0;
      rec_idx_q  <= '0;
      keep_q     <= '0;
      guard_q    <= '0;
      upd_q      <= 1'b0;
      gate_q     <= 1'b0;
      data_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q != ST_IDLE && st_q != ST_ARMED && sector_mark_i) begin
        // next mark ends whatever is in flight
        gate_q <= 1'b0;
        data_q <= 1'b0;
        done_q <= 1'b1;
        st_q   <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_IDLE: if (start_i) begin
            st_q   <= ST_ARMED;
            upd_q  <= update_i && (keep_i != '0);
            keep_q <= keep_i;
          end
          ST_ARMED: if (sector_mark_i) begin
            rec_idx_q <= '0;
            guard_q   <= '0;
            st_q      <= upd_q ? ST_READ : ST_GUARD;
          end
          ST_READ: if (rx_done) begin
            if (rec_idx_q == keep_q - REC_W'(1)) begin
              // hand-off: gate opens on the very next tick
              rec_idx_q <= keep_q;
              guard_q   <= GUARD_C;
              st_q      <= ST_GUARD;
            end else begin
              rec_idx_q <= rec_idx_q + 1'b1;
            end
          end
          ST_GUARD: if (bit_tick_i) begin
            if (guard_q == GUARD_C) begin
              gate_q    <= 1'b1;
              data_q    <= 1'b0;
              bit_cnt_q <= CNT_W'(1);
              st_q      <= ST_PRE;
            end else begin
              guard_q <= guard_q + 1'b1;
            end
          end
          ST_PRE: if (bit_tick_i) begin
            if (pre_end) begin
              data_q     <= 1'b1;
              bit_cnt_q  <= '0;
              word_idx_q <= '0;
              st_q       <= ST_DATA;
            end else begin
              data_q    <= 1'b0;
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
          ST_DATA: if (bit_tick_i) begin
            data_q <= tx_msb;
            if (word_end) begin
              bit_cnt_q <= '0;
              if (last_word) st_q <= ST_CHECK;
              else           word_idx_q <= word_idx_q + 1'b1;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
          ST_CHECK: if (bit_tick_i) begin
            data_q <= tx_msb;
            if (word_end) begin
              bit_cnt_q <= '0;
              if (last_rec) begin
                st_q <= ST_POST;
              end else begin
                rec_idx_q <= rec_idx_q + 1'b1;
                st_q      <= ST_PRE;
              end
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
          ST_POST: if (bit_tick_i) begin
            data_q <= 1'b0;
            if (bit_cnt_q == POST_C) begin
              gate_q <= 1'b0;
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign word_ready_o = tx_load;
  assign wr_data_o    = data_q;
  assign wr_gate_o    = gate_q;
  assign done_o       = done_q;
  assign chk_fail_o   = rx_bad;

  a_r2_gate_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_gate_o) |-> $past(bit_tick_i));
  a_r3_quiet_without_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_gate_o |-> !wr_data_o);
  a_r5_fall_gives_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_gate_o) |-> done_o);
  a_r6_mark_kills_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_gate_o && sector_mark_i) |=> (!wr_gate_o && done_o));
  a_r9_take_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ready_o |-> (bit_tick_i && wr_gate_o));
  a_r3_data_moves_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_tick_i && !sector_mark_i) |=> ($stable(wr_data_o) && $stable(wr_gate_o)));
endmodule

// File: tb/sector_write_seq_tb.sv
module sector_write_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 3, RW = 2, PF = 4, PU = 8, PB = 5, GT = 3;
  localparam int NP = 220;
  localparam int KW = $clog2(NR);
  localparam logic [15:0] SEED = 16'h0151;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, upd = 1'b0, mark = 1'b0, tick = 1'b0, rd_bit = 1'b0, vld = 1'b0;
  logic [KW-1:0] keep = '0;
  logic [15:0] word;
  logic ready, wdata, gate, done, cfail;

  int n_checks = 0, n_errs = 0;
  int pat = 0, xfer_cnt = 0, xfer_base = 0;
  int mark_p, abort_p, extra_p;
  int n_done, n_fail, exp_xfer, exp_fail;
  int wt, rt;
  bit rd_src[NP], exp_g[NP], exp_d[NP], cap_g[NP], cap_d[NP];

  sector_write_seq #(.N_RECS(NR), .REC_WORDS(RW), .PRE_FULL(PF), .PRE_UPD(PU),
                     .POST_BITS(PB), .GUARD_TICKS(GT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .update_i(upd), .keep_i(keep),
    .sector_mark_i(mark), .bit_tick_i(tick), .rd_bit_i(rd_bit), .word_i(word),
    .word_valid_i(vld), .word_ready_o(ready), .wr_data_o(wdata), .wr_gate_o(gate),
    .done_o(done), .chk_fail_o(cfail));

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] wval(int p, int k);
    case (p)
      0: return 16'h1234 + 16'(k) * 16'h1111;
      1: return 16'hFFFF;
      2: return (k % 2 == 1) ? 16'hAAAA : 16'h5555;
      default: return 16'h8000 >> k;
    endcase
  endfunction

  function automatic logic [15:0] rdw(int r, int w);
    return 16'h3C5A ^ 16'(r * 256 + w * 17 + 1);
  endfunction

  always @(posedge clk) if (vld && ready) xfer_cnt <= xfer_cnt + 1;
  assign word = wval(pat, xfer_cnt - xfer_base);

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(bit d);
    if (wt < NP) begin exp_g[wt] = 1'b1; exp_d[wt] = d; end
    wt++;
  endtask

  task automatic rput(bit d);
    if (rt < NP) rd_src[rt] = d;
    rt++;
  endtask

  // expected serial stream from the requirements
  task automatic build(bit u, int k, bit v, int bad_rec);
    int first, pre, nw, tk, lim;
    logic [15:0] w, c;
    bit eu;
    for (int p = 0; p < NP; p++) begin exp_g[p] = 0; exp_d[p] = 0; rd_src[p] = 0; end
    exp_xfer = 0; exp_fail = 0; nw = 0;
    lim = (abort_p >= 0) ? abort_p : NP;
    eu = u && (k != 0);
    if (eu) begin
      rt = mark_p + 3;
      for (int r = 0; r < k; r++) begin
        rt += 3;
        rput(1'b1);
        c = SEED;
        for (int i = 0; i < RW; i++) begin
          w = rdw(r, i); c ^= w;
          for (int b = 15; b >= 0; b--) rput(w[b]);
        end
        if (r == bad_rec) begin c ^= 16'h0004; exp_fail++; end
        for (int b = 15; b >= 0; b--) rput(c[b]);
      end
      wt = rt; first = k; pre = PU;
    end else begin
      wt = mark_p + GT + 1; first = 0; pre = PF;
    end
    for (int r = first; r < NR; r++) begin
      for (int i = 0; i < pre; i++) put(1'b0);
      tk = wt;
      put(1'b1);
      c = SEED;
      for (int i = 0; i < RW; i++) begin
        w = v ? wval(pat, nw) : 16'h0000;
        nw++;
        if (v && tk <= lim) exp_xfer++;
        c ^= w;
        for (int b = 15; b >= 0; b--) put(w[b]);
        tk = wt - 1;
      end
      for (int b = 15; b >= 0; b--) put(c[b]);
    end
    for (int i = 0; i < PB; i++) put(1'b0);
    if (abort_p >= 0)
      for (int p = abort_p + 1; p < NP; p++) begin exp_g[p] = 0; exp_d[p] = 0; end
  endtask

  task automatic sample_pulses();
    n_done += int'(done);
    n_fail += int'(cfail);
  endtask

  task automatic run_periods();
    for (int p = 0; p < NP; p++) begin
      @(negedge clk); sample_pulses(); tick = 1'b1; rd_bit = rd_src[p];
      @(negedge clk); sample_pulses(); tick = 1'b0; cap_g[p] = gate; cap_d[p] = wdata;
      @(negedge clk); sample_pulses();
      if (p == mark_p || p == abort_p) mark = 1'b1;
      if (p == extra_p) begin start = 1'b1; upd = 1'b1; keep = KW'(1); end
      @(negedge clk); sample_pulses(); mark = 1'b0; start = 1'b0;
    end
  endtask

  task automatic run_op(string req, bit u, int k, bit v, int bad_rec);
    int fg, fd;
    vld = v;
    build(u, k, v, bad_rec);
    xfer_base = xfer_cnt; n_done = 0; n_fail = 0;
    @(negedge clk); start = 1'b1; upd = u; keep = KW'(k);
    @(negedge clk); start = 1'b0;
    run_periods();
    fg = -1; fd = -1;
    for (int p = NP - 1; p >= 0; p--) begin
      if (cap_g[p] != exp_g[p]) fg = p;
      if (cap_d[p] != exp_d[p]) fd = p;
    end
    if (fg < 0) check(1'b1, req, "gate", 0, 0);
    else check(1'b0, req, $sformatf("gate at tick %0d", fg), int'(cap_g[fg]), int'(exp_g[fg]));
    if (fd < 0) check(1'b1, req, "data", 0, 0);
    else check(1'b0, req, $sformatf("data at tick %0d", fd), int'(cap_d[fd]), int'(exp_d[fd]));
    check(n_done == 1, (abort_p >= 0) ? "R6" : "R5", "done pulses", n_done, 1);
    check(xfer_cnt - xfer_base == exp_xfer, "R9", "word transfers", xfer_cnt - xfer_base, exp_xfer);
    check(n_fail == exp_fail, "R8", "check-fail pulses", n_fail, exp_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    mark_p = -1; abort_p = -1; extra_p = -1;
    repeat (3) @(negedge clk);
    check(gate == 1'b0, "R1", "gate in reset", int'(gate), 0);
    check(wdata == 1'b0, "R1", "data in reset", int'(wdata), 0);
    check(done == 1'b0 && cfail == 1'b0, "R1", "pulses in reset", int'(done | cfail), 0);
    check(ready == 1'b0, "R1", "ready in reset", int'(ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(gate == 1'b0 && wdata == 1'b0, "R1", "outputs after reset", int'(gate | wdata), 0);

    // R10: mark while idle does nothing
    for (int p = 0; p < NP; p++) begin rd_src[p] = 0; exp_g[p] = 0; end
    mark_p = 5; n_done = 0;
    run_periods();
    begin
      int ng = 0;
      for (int p = 0; p < NP; p++) ng += int'(cap_g[p]);
      check(ng == 0, "R10", "gate ticks after idle mark", ng, 0);
    end
    check(n_done == 0, "R10", "done after idle mark", n_done, 0);

    // R2 R3 R4 R5: full writes over word patterns and mark positions
    for (int q = 0; q < 4; q++) begin
      pat = q; mark_p = (q == 3) ? 7 : 2;
      extra_p = (q == 2) ? 40 : -1;  // R10: start while busy ignored
      run_op((q == 2) ? "R10" : "R3", 1'b0, 0, 1'b1, -1);
    end
    extra_p = -1; mark_p = 2;

    // R9: absent words become zeros
    pat = 0;
    run_op("R9", 1'b0, 0, 1'b0, -1);

    // R7: updates keeping one and two records
    pat = 2;
    run_op("R7", 1'b1, 1, 1'b1, -1);
    pat = 3;
    run_op("R7", 1'b1, 2, 1'b1, -1);

    // R11: update with nothing kept equals a full write
    pat = 0;
    run_op("R11", 1'b1, 0, 1'b1, -1);

    // R8: bad read check word
    run_op("R8", 1'b1, 2, 1'b1, 1);
    run_op("R8", 1'b1, 1, 1'b1, 0);

    // R6: second mark mid-field aborts
    pat = 1;
    abort_p = mark_p + GT + 1 + PF + 12;
    run_op("R6", 1'b0, 0, 1'b1, -1);
    abort_p = mark_p + GT + 1 + 60;
    run_op("R6", 1'b0, 0, 1'b1, -1);
    abort_p = -1;

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end
endmodule